// File: doc/BRIEF.md
# Framed Word Serializer with Sync Generator

This block turns a stream of parallel words into a framed serial bit stream for a receiver that recovers its clock from the data. Each word is wrapped in a frame of twelve bit times: a high start bit, the ten data bits with the least significant bit first, and a low end bit. The fall from the end bit of one frame into the start bit of the next gives the receiver a rising edge at every frame boundary. The bit rate is set by a one-cycle bit-enable pulse, so one frame spans twelve such pulses, however many clock cycles lie between them.

Two synchronization request inputs replace data frames with a training frame of six ones followed by six zeros. That frame has exactly one rising edge, at the boundary, so a receiver cannot lock onto a false position. Either request may be tied to a receiver's active-high loss indication: training frames then repeat until the receiver locks and drops the request. An enable input holds the line low by sending idle frames. All three control inputs and the parallel word are sampled only on the bit pulse that starts a frame, so a frame in progress is never cut short or altered.

Top module: `framed_serializer`

## Requirements
- R1: While reset is asserted and after its release until the first bit pulse, `serialOut` and `wordTake` are low; the first bit pulse after reset starts a frame.
- R2: A frame occupies exactly 12 bit pulses; a new frame starts on the bit pulse after the 12th bit of the previous one.
- R3: A data frame sends, in order, a 1 (start), `wordIn` bits 0 through 9, and a 0 (end).
- R4: `wordIn` is captured on the bit pulse that starts a data frame; `wordTake` is high for exactly the one clock cycle after that pulse and at no other time; later changes to `wordIn` do not reach the frame in progress.
- R5: When `enable` is high and either `syncReqA` or `syncReqB` is high at a frame start, the frame is six 1 bits followed by six 0 bits, and no word is captured.
- R6: A training frame carries exactly one rising edge, at its start boundary; the stream returns to data frames at the first frame start where both requests are low.
- R7: Changes on `syncReqA`, `syncReqB` and `enable` within a frame have no effect on that frame; they take effect at the next frame start.
- R8: When `enable` is low at a frame start, the frame is twelve 0 bits regardless of the sync requests, and no word is captured.
- R9: `serialOut` changes only on the clock edge where `bitTick` is high; between bit pulses it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-cycle pulse per serial bit time |
| enable | input | 1 | High to send data or training frames, low for idle frames |
| syncReqA | input | 1 | Training frame request, first source |
| syncReqB | input | 1 | Training frame request, second source |
| wordIn | input | 10 | Parallel word for the next data frame |
| serialOut | output | 1 | Serial line output, registered |
| wordTake | output | 1 | One-cycle pulse: `wordIn` has been captured |

## Verification
Every result of the block is due on the clock edge of a bit pulse: the serial bit it carries appears at `serialOut` one cycle later, and `wordTake` rises on that same edge when the pulse starts a data frame. The bench drives each pulse on a falling edge and samples on the next falling edge, then holds `bitTick` low for zero to two extra cycles and samples again to confirm that nothing moved. Expected frames are built from the values the bench set before the starting pulse, so inputs it changes mid-frame must not show up until the next frame, and received data frames are decoded back into words and compared with the words that were sent.

// File: rtl/serfrm_pkg.sv
package serfrm_pkg;

  typedef enum logic [1:0] {
    KIND_IDLE = 2'd0,
    KIND_DATA = 2'd1,
    KIND_SYNC = 2'd2
  } frameKind_t;

  typedef struct packed {
    logic       load;
    logic       shift;
    frameKind_t kind;
  } frameStrobe_t;

endpackage

// File: rtl/serfrm_ctrl.sv
module serfrm_ctrl
  import serfrm_pkg::*;
#(
  parameter int FRAME_W = 12
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         bitTick,
  input  logic         enable,
  input  logic         syncReqA,
  input  logic         syncReqB,
  output frameStrobe_t strobe
);

  localparam int POS_W = $clog2(FRAME_W);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_W - 1);

  logic [POS_W-1:0] bitPos;
  frameKind_t       kindReg;
  frameKind_t       nextKind;
  logic             atBoundary;
  logic             anySync;

  assign atBoundary = (bitPos == LAST_POS);
  assign anySync    = syncReqA | syncReqB;

  always_comb begin
    if (!enable)      nextKind = KIND_IDLE;
    else if (anySync) nextKind = KIND_SYNC;
    else              nextKind = KIND_DATA;
  end

  always_comb begin
    strobe.load  = bitTick & atBoundary;
    strobe.shift = bitTick & ~atBoundary;
    strobe.kind  = strobe.load ? nextKind : kindReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitPos  <= LAST_POS;
      kindReg <= KIND_IDLE;
    end else if (bitTick) begin
      if (atBoundary) begin
        bitPos  <= '0;
        kindReg <= nextKind;
      end else begin
        bitPos  <= bitPos + 1'b1;
      end
    end
  end

  // R9: the bit position moves only on a bit pulse
  p_pos_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !bitTick |=> $stable(bitPos));

  // R2: the position never leaves the frame
  p_pos_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    bitPos <= LAST_POS);

  // R2: the last bit is followed by the first bit of a new frame
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (bitTick && bitPos == LAST_POS) |=> (bitPos == '0));

  // R7: the frame kind is decided only at a frame start
  p_kind_boundary_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(kindReg));

endmodule

// File: rtl/serfrm_datapath.sv
module serfrm_datapath
  import serfrm_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  frameStrobe_t      strobe,
  input  logic [DATA_W-1:0] wordIn,
  output logic              serialOut,
  output logic              wordTake
);

  localparam int FRAME_W   = DATA_W + 2;
  localparam int SYNC_ONES = FRAME_W / 2;

  logic [FRAME_W-1:0] dataFrame;
  logic [FRAME_W-1:0] syncFrame;
  logic [FRAME_W-1:0] newFrame;
  logic [FRAME_W-2:0] shiftReg;

  // Send order: index 0 leaves first.
  assign dataFrame[0]         = 1'b1;
  assign dataFrame[FRAME_W-1] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_dataBits
      assign dataFrame[gi+1] = wordIn[gi];
    end
    for (gi = 0; gi < FRAME_W; gi++) begin : g_syncBits
      assign syncFrame[gi] = (gi < SYNC_ONES);
    end
  endgenerate

  always_comb begin
    unique case (strobe.kind)
      KIND_DATA: newFrame = dataFrame;
      KIND_SYNC: newFrame = syncFrame;
      default:   newFrame = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      serialOut <= 1'b0;
      shiftReg  <= '0;
      wordTake  <= 1'b0;
    end else if (strobe.load) begin
      serialOut <= newFrame[0];
      shiftReg  <= newFrame[FRAME_W-1:1];
      wordTake  <= (strobe.kind == KIND_DATA);
    end else if (strobe.shift) begin
      serialOut <= shiftReg[0];
      shiftReg  <= {1'b0, shiftReg[FRAME_W-2:1]};
      wordTake  <= 1'b0;
    end else begin
      wordTake  <= 1'b0;
    end
  end

  // R9: the line holds between bit pulses
  p_hold_out_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.load || strobe.shift) |=> $stable(serialOut));

  // R3: a data frame opens with a high start bit and a capture pulse
  p_start_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.kind == KIND_DATA) |=> (serialOut && wordTake));

  // R5: a training frame opens high without a capture pulse
  p_sync_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.kind == KIND_SYNC) |=> (serialOut && !wordTake));

  // R8: an idle frame opens low without a capture pulse
  p_idle_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.kind == KIND_IDLE) |=> (!serialOut && !wordTake));

  // R4: the capture pulse lasts a single cycle
  p_take_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    wordTake |=> !wordTake);

endmodule

// File: rtl/framed_serializer.sv
module framed_serializer
  import serfrm_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic              enable,
  input  logic              syncReqA,
  input  logic              syncReqB,
  input  logic [DATA_W-1:0] wordIn,
  output logic              serialOut,
  output logic              wordTake
);

  localparam int FRAME_W = DATA_W + 2;

  frameStrobe_t strobe;

  serfrm_ctrl #(.FRAME_W(FRAME_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bitTick  (bitTick),
    .enable   (enable),
    .syncReqA (syncReqA),
    .syncReqB (syncReqB),
    .strobe   (strobe)
  );

  serfrm_datapath #(.DATA_W(DATA_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wordIn    (wordIn),
    .serialOut (serialOut),
    .wordTake  (wordTake)
  );

endmodule

// File: tb/tb_framed_serializer.sv
module tb_framed_serializer;

  localparam int DW = 10;
  localparam int FW = DW + 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          bitTick = 1'b0;
  logic          enable = 1'b0;
  logic          syncReqA = 1'b0;
  logic          syncReqB = 1'b0;
  logic [DW-1:0] wordIn = '0;
  logic          serialOut;
  logic          wordTake;

  int  checks = 0;
  int  fails = 0;
  bit  done = 0;
  logic prevBit = 1'b0;

  always #10 clk = ~clk;

  framed_serializer #(.DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .enable(enable),
    .syncReqA(syncReqA), .syncReqB(syncReqB), .wordIn(wordIn),
    .serialOut(serialOut), .wordTake(wordTake)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One frame; inputs set before its first pulse, optionally flipped mid-frame.
  task automatic runFrame(input logic [DW-1:0] word, input logic sa, input logic sb,
                          input logic en, input int gap, input bit scramble);
    logic [FW-1:0] expF;
    logic [FW-1:0] gotF;
    int kind;   // 0 idle, 1 data, 2 sync
    int rises;
    string tag;
    wordIn = word; syncReqA = sa; syncReqB = sb; enable = en;
    if (!en) kind = 0; else if (sa || sb) kind = 2; else kind = 1;
    for (int k = 0; k < FW; k++) begin
      if (kind == 1) expF[k] = (k == 0) ? 1'b1 : (k == FW-1) ? 1'b0 : word[k-1];
      else if (kind == 2) expF[k] = (k < FW/2);
      else expF[k] = 1'b0;
    end
    tag = scramble ? "R7" : (kind == 1) ? "R3" : (kind == 2) ? "R5" : "R8";
    rises = 0;
    for (int b = 0; b < FW; b++) begin
      if (scramble && b == 5) begin
        wordIn = ~word; syncReqA = ~sa; syncReqB = ~sb; enable = ~en;
      end
      bitTick = 1'b1;
      @(negedge clk);
      bitTick = 1'b0;
      gotF[b] = serialOut;
      check(serialOut == expF[b], tag, serialOut, expF[b]);
      if (b == 0) check(wordTake == (kind == 1), "R4 capture pulse", wordTake, kind == 1);
      if (prevBit == 1'b0 && serialOut == 1'b1) rises++;
      prevBit = serialOut;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        check(serialOut == gotF[b], "R9 hold between pulses", serialOut, gotF[b]);
        check(wordTake == 1'b0, "R4 single pulse", wordTake, 0);
      end
      if (b == 0 && gap == 0) begin end
    end
    if (kind == 1) begin
      check(gotF[0] == 1'b1 && gotF[FW-1] == 1'b0, "R2 framing bits", gotF[0], 1);
      check(gotF[FW-2:1] == word, "R3 deframed word", gotF[FW-2:1], word);
    end
    if (kind == 2) check(rises == 1, "R6 one rising edge", rises, 1);
    if (kind == 0) check(gotF == '0, "R8 idle frame", gotF, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) begin
      @(negedge clk);
      check(serialOut == 1'b0, "R1 line low in reset", serialOut, 0);
      check(wordTake == 1'b0, "R1 no capture in reset", wordTake, 0);
    end
    rstN = 1'b1;
    repeat (2) begin
      @(negedge clk);
      check(serialOut == 1'b0 && wordTake == 1'b0, "R1 quiet before first pulse", serialOut, 0);
    end

    // R1/R3: first frame after reset, then every word value
    for (int w = 0; w < (1 << DW); w++)
      runFrame(DW'(w), 1'b0, 1'b0, 1'b1, w % 3, 1'b0);

    // R5/R6: training frames from each request source
    for (int s = 1; s < 4; s++)
      for (int r = 0; r < 3; r++)
        runFrame(DW'(37 * s + r * 211), s[0], s[1], 1'b1, r % 2, 1'b0);
    // R6: back to data after requests drop
    runFrame(10'h3FF, 1'b0, 1'b0, 1'b1, 0, 1'b0);
    runFrame(10'h201, 1'b0, 1'b0, 1'b1, 1, 1'b0);

    // R8: idle frames, sync requests ignored while disabled
    runFrame(10'h155, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    runFrame(10'h2AA, 1'b1, 1'b1, 1'b0, 2, 1'b0);
    runFrame(10'h0F0, 1'b0, 1'b0, 1'b1, 0, 1'b0);

    // R7/R4: mid-frame changes on every input
    runFrame(10'h1C3, 1'b0, 1'b0, 1'b1, 1, 1'b1);
    runFrame(10'h00F, 1'b1, 1'b0, 1'b1, 0, 1'b1);
    runFrame(10'h3C0, 1'b0, 1'b1, 1'b0, 2, 1'b1);
    runFrame(10'h2B4, 1'b0, 1'b0, 1'b1, 0, 1'b0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule